// File: doc/BRIEF.md
# Configurable GPIO Port Register Bank

This block controls one port of up to eight general-purpose pins. A small register bus (address, write strobe, byte-wide write data and a flag that marks a read as the read half of a read-modify-write) reaches a set of per-bit registers. These registers hold the output data, the direction, the input gate, the pull-up request, two drive-strength fields and two input-threshold fields. A read-only register returns the synchronized pin level.

Each pin also connects to an on-chip peripheral, which supplies an output bit and an output-enable bit and receives the gated input. For every pin the block works out, and registers, the level to drive, the pad output enable, the pull-up enable, a 2-bit drive-strength code and a 2-bit input-threshold code. The pad is treated as a plain digital input with digital control lines. Pins are sampled through a two-flop synchronizer.

Top module: `gpio_port_bank`

## Requirements
- R1: Pad level per pin. With direction 1 and the peripheral disabled, `pad_out` is the data bit. With direction 1 and the peripheral enabled, it is the data bit ORed with `per_out`. With direction 0 it is `per_out`. It is registered, one clock after its inputs.
- R2: `pad_oe` for each pin is the direction bit ORed with `per_oe`, registered one clock after its inputs.
- R3: A plain read (`bus_rmw`=0) of the data register at offset 0 returns the stored bit for output-direction pins. For input-direction pins it returns the synchronized pin level ANDed with the input-enable bit.
- R4: A read with `bus_rmw`=1 at offset 0 returns the stored data register, whatever the direction or peripheral enable. When a write to that offset falls in the same cycle, the read returns the value held before the write.
- R5: The pin-state register at offset 3 returns the synchronized pin ANDed with input enable, so a disabled bit reads 0. A pin change reaches `bus_rdata` on the third rising edge after it.
- R6: The pull-up request (offset 4) reaches `pad_pu` only while the pin is not driven (`pad_oe` condition of R2 false). Pins set in the `OD_MASK` parameter (default bit 7 only) keep the request while driven.
- R7: `pad_pu` is 0 for any pin with `analog_sel` set. It is 0 on every pin while both `pu_suppress` and `low_power` are 1.
- R8: Drive code per pin, bits [2i+1:2i] of `pad_drv`. The high-drive bit (offset 6) gives 2'b10 (high current) when `HIGH_DRIVE`=1. Otherwise the reduce bit (offset 5) gives 2'b01 (reduced) when 1 and 2'b00 (normal) when 0.
- R9: Input-threshold code per pin, bits [2i+1:2i] of `pad_lvl`, is {extended bit (offset 8), base bit (offset 7)}. The codes are 00 CMOS 0.3/0.7, 01 hysteresis, 10 TTL and 11 CMOS 0.2/0.8.
- R10: Synchronous reset clears every register. After reset all pins are inputs with the input gate off, and `pad_oe` and `pad_pu` are 0.
- R11: Writing the data register while a pin is an input stores the value. A later switch to output drives that stored value on the next registered update.
- R12: `per_in` equals the synchronized pin level ANDed with the input-enable bit (offset 2).
- R13: Writable registers read back what was written: data 0, direction 1, input enable 2, pull-up 4, reduce 5, high-drive 6, level base 7, level extended 8. `bus_rdata` is registered one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | NPIN | Write data |
| bus_rmw | input | 1 | Marks the read as part of a read-modify-write |
| bus_rdata | output | NPIN | Registered read data |
| per_out | input | NPIN | Peripheral output bits |
| per_oe | input | NPIN | Peripheral output enables |
| analog_sel | input | NPIN | Pin selected as analog input |
| pu_suppress | input | 1 | Global pull-up suppress setting |
| low_power | input | 1 | Stop or timer low-power state |
| pin_in | input | NPIN | Pad input levels |
| per_in | output | NPIN | Gated, synchronized input to peripheral |
| pad_out | output | NPIN | Level to drive |
| pad_oe | output | NPIN | Pad output enable |
| pad_pu | output | NPIN | Pull-up enable |
| pad_drv | output | 2*NPIN | Drive-strength codes |
| pad_lvl | output | 2*NPIN | Input-threshold codes |

## Verification
Two cases can land in the same cycle: a write to the data register and a read-modify-write read of it. The bench drives a write and a flagged read to offset 0 on one edge and expects the old contents back, then reads the new value on its own. A second collision puts a pin change together with a read of the pin-state register. Sampling on each of the next three edges judges that the synchronizer and read register hold the old level for exactly two edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_DATA  = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIR   = 4'd1;
  localparam logic [ADDR_W-1:0] A_INEN  = 4'd2;
  localparam logic [ADDR_W-1:0] A_PSTAT = 4'd3;
  localparam logic [ADDR_W-1:0] A_PULL  = 4'd4;
  localparam logic [ADDR_W-1:0] A_DRED  = 4'd5;
  localparam logic [ADDR_W-1:0] A_DHI   = 4'd6;
  localparam logic [ADDR_W-1:0] A_LVLB  = 4'd7;
  localparam logic [ADDR_W-1:0] A_LVLE  = 4'd8;

  localparam logic [1:0] DRV_NORMAL  = 2'b00;
  localparam logic [1:0] DRV_REDUCED = 2'b01;
  localparam logic [1:0] DRV_HIGH    = 2'b10;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  output logic [NPIN-1:0]   data_q,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   ie_q,
  output logic [NPIN-1:0]   pu_q,
  output logic [NPIN-1:0]   dred_q,
  output logic [NPIN-1:0]   dhi_q,
  output logic [NPIN-1:0]   lvlb_q,
  output logic [NPIN-1:0]   lvle_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      ie_q   <= '0;
      pu_q   <= '0;
      dred_q <= '0;
      dhi_q  <= '0;
      lvlb_q <= '0;
      lvle_q <= '0;
    end else if (we) begin
      case (addr)
        A_DATA: data_q <= wdata;
        A_DIR:  dir_q  <= wdata;
        A_INEN: ie_q   <= wdata;
        A_PULL: pu_q   <= wdata;
        A_DRED: dred_q <= wdata;
        A_DHI:  dhi_q  <= wdata;
        A_LVLB: lvlb_q <= wdata;
        A_LVLE: lvle_q <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pkg::*;
#(
  parameter int              NPIN       = 8,
  parameter bit              HIGH_DRIVE = 1'b1,
  parameter logic [NPIN-1:0] OD_MASK    = {1'b1, {(NPIN-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   data_q,
  input  logic [NPIN-1:0]   dir_q,
  input  logic [NPIN-1:0]   pu_q,
  input  logic [NPIN-1:0]   dred_q,
  input  logic [NPIN-1:0]   dhi_q,
  input  logic [NPIN-1:0]   lvlb_q,
  input  logic [NPIN-1:0]   lvle_q,
  input  logic [NPIN-1:0]   per_out,
  input  logic [NPIN-1:0]   per_oe,
  input  logic [NPIN-1:0]   analog_sel,
  input  logic              pu_suppress,
  input  logic              low_power,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_pu,
  output logic [2*NPIN-1:0] pad_drv,
  output logic [2*NPIN-1:0] pad_lvl
);
  logic              pu_block_all;
  logic [NPIN-1:0]   out_d, oe_d, pu_d;
  logic [2*NPIN-1:0] drv_d, lvl_d;

  assign pu_block_all = pu_suppress & low_power;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic driven;
    assign driven   = dir_q[i] | per_oe[i];
    assign oe_d[i]  = driven;
    assign out_d[i] = dir_q[i] ? (data_q[i] | (per_oe[i] & per_out[i])) : per_out[i];

    if (OD_MASK[i]) begin : g_keep_pu
      assign pu_d[i] = pu_q[i] & ~analog_sel[i] & ~pu_block_all;
    end else begin : g_drop_pu
      assign pu_d[i] = pu_q[i] & ~driven & ~analog_sel[i] & ~pu_block_all;
    end

    if (HIGH_DRIVE) begin : g_hd
      assign drv_d[2*i +: 2] = dhi_q[i] ? DRV_HIGH : (dred_q[i] ? DRV_REDUCED : DRV_NORMAL);
    end else begin : g_nohd
      assign drv_d[2*i +: 2] = dred_q[i] ? DRV_REDUCED : DRV_NORMAL;
    end

    assign lvl_d[2*i +: 2] = {lvle_q[i], lvlb_q[i]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pad_pu  <= '0;
      pad_drv <= '0;
      pad_lvl <= '0;
    end else begin
      pad_out <= out_d;
      pad_oe  <= oe_d;
      pad_pu  <= pu_d;
      pad_drv <= drv_d;
      pad_lvl <= lvl_d;
    end
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_pkg::*;
#(
  parameter int              NPIN       = 8,
  parameter bit              HIGH_DRIVE = 1'b1,
  parameter logic [NPIN-1:0] OD_MASK    = {1'b1, {(NPIN-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        bus_addr,
  input  logic              bus_we,
  input  logic [NPIN-1:0]   bus_wdata,
  input  logic              bus_rmw,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   per_out,
  input  logic [NPIN-1:0]   per_oe,
  input  logic [NPIN-1:0]   analog_sel,
  input  logic              pu_suppress,
  input  logic              low_power,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   per_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_pu,
  output logic [2*NPIN-1:0] pad_drv,
  output logic [2*NPIN-1:0] pad_lvl
);
  logic [NPIN-1:0] data_q, dir_q, ie_q, pu_q, dred_q, dhi_q, lvlb_q, lvle_q;
  logic [NPIN-1:0] pin_sync, pin_gated;

  gpio_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .data_q(data_q), .dir_q(dir_q), .ie_q(ie_q), .pu_q(pu_q),
    .dred_q(dred_q), .dhi_q(dhi_q), .lvlb_q(lvlb_q), .lvle_q(lvle_q)
  );

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  gpio_pad_ctrl #(.NPIN(NPIN), .HIGH_DRIVE(HIGH_DRIVE), .OD_MASK(OD_MASK)) u_pad (
    .clk(clk), .rst(rst),
    .data_q(data_q), .dir_q(dir_q), .pu_q(pu_q), .dred_q(dred_q), .dhi_q(dhi_q),
    .lvlb_q(lvlb_q), .lvle_q(lvle_q),
    .per_out(per_out), .per_oe(per_oe), .analog_sel(analog_sel),
    .pu_suppress(pu_suppress), .low_power(low_power),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pad_drv(pad_drv), .pad_lvl(pad_lvl)
  );

  assign pin_gated = pin_sync & ie_q;
  assign per_in    = pin_gated;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_DATA:  bus_rdata <= bus_rmw ? data_q : ((dir_q & data_q) | (~dir_q & pin_gated));
        A_DIR:   bus_rdata <= dir_q;
        A_INEN:  bus_rdata <= ie_q;
        A_PSTAT: bus_rdata <= pin_gated;
        A_PULL:  bus_rdata <= pu_q;
        A_DRED:  bus_rdata <= dred_q;
        A_DHI:   bus_rdata <= dhi_q;
        A_LVLB:  bus_rdata <= lvlb_q;
        A_LVLE:  bus_rdata <= lvle_q;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk
  import gpio_pkg::*;
#(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      bus_addr,
  input logic            bus_rmw,
  input logic [NPIN-1:0] bus_rdata,
  input logic [NPIN-1:0] per_oe,
  input logic [NPIN-1:0] analog_sel,
  input logic            pu_suppress,
  input logic            low_power,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_pu,
  input logic [NPIN-1:0] data_q,
  input logic [NPIN-1:0] dir_q,
  input logic [NPIN-1:0] ie_q
);
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (dir_q == '0 && ie_q == '0));

  p_oe_merge_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pad_oe == $past(dir_q | per_oe)));

  p_rmw_stored_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_DATA && bus_rmw) |=> (bus_rdata == $past(data_q)));

  p_pstate_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_PSTAT) |=> ((bus_rdata & ~$past(ie_q)) == '0));

  p_pu_analog_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_pu & $past(analog_sel)) == '0));

  p_pu_lowpwr_r7: assert property (@(posedge clk) disable iff (rst)
    (pu_suppress && low_power) |=> (pad_pu == '0));
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rmw(bus_rmw), .bus_rdata(bus_rdata),
  .per_oe(per_oe), .analog_sel(analog_sel), .pu_suppress(pu_suppress),
  .low_power(low_power), .pad_oe(pad_oe), .pad_pu(pad_pu),
  .data_q(data_q), .dir_q(dir_q), .ie_q(ie_q)
);

// File: tb/gpio_port_bank_bench.sv
module gpio_port_bank_bench;
  localparam int NPIN = 8;
  localparam int S_RD = 0, S_OUT = 1, S_OE = 2, S_PU = 3, S_DRV = 4, S_LVL = 5, S_PIN = 6;

  logic clk = 1'b0;
  logic rst;
  logic [3:0] bus_addr;
  logic bus_we, bus_rmw, pu_suppress, low_power;
  logic [NPIN-1:0] bus_wdata, bus_rdata, per_out, per_oe, analog_sel, pin_in, per_in;
  logic [NPIN-1:0] pad_out, pad_oe, pad_pu;
  logic [2*NPIN-1:0] pad_drv, pad_lvl;

  typedef struct {
    int          sel;
    string       req;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_port_bank u_gpio_port_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rmw(bus_rmw), .bus_rdata(bus_rdata), .per_out(per_out), .per_oe(per_oe),
    .analog_sel(analog_sel), .pu_suppress(pu_suppress), .low_power(low_power),
    .pin_in(pin_in), .per_in(per_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_drv(pad_drv), .pad_lvl(pad_lvl)
  );

  function automatic logic [15:0] observe(int sel);
    case (sel)
      S_RD:    return {8'h00, bus_rdata};
      S_OUT:   return {8'h00, pad_out};
      S_OE:    return {8'h00, pad_oe};
      S_PU:    return {8'h00, pad_pu};
      S_DRV:   return pad_drv;
      S_LVL:   return pad_lvl;
      default: return {8'h00, per_in};
    endcase
  endfunction

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it  = q.pop_front();
      got = observe(it.sel);
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
      end
    end
  end

  // wait one rising edge, queue the expectation, let the monitor consume it
  task automatic chk(int sel, string req, logic [15:0] exp);
    item_t it;
    @(posedge clk);
    it.sel = sel; it.req = req; it.exp = exp;
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic rmw, string req, logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rmw = rmw;
    chk(S_RD, req, {8'h00, exp});
    bus_rmw = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_rmw = 1'b0;
    per_out = '0; per_oe = '0; analog_sel = '0; pu_suppress = 1'b0; low_power = 1'b0;
    pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R10 reset state
    chk(S_OE, "R10", 16'h0000);
    chk(S_PU, "R10", 16'h0000);
    rd(4'd1, 1'b0, "R10", 8'h00);
    rd(4'd2, 1'b0, "R10", 8'h00);

    // R13 readback
    wr(4'd4, 8'hA5);
    rd(4'd4, 1'b0, "R13", 8'hA5);

    // R11 data written while input, then output drives it
    wr(4'd0, 8'h3C);
    chk(S_OE, "R11", 16'h0000);
    wr(4'd1, 8'hFF);
    chk(S_OUT, "R11", 16'h003C);
    chk(S_OE, "R2", 16'h00FF);
    rd(4'd0, 1'b0, "R3", 8'h3C);

    // R1 OR merge for output pins with peripheral enabled
    @(negedge clk); per_oe = 8'h0F; per_out = 8'h81;
    chk(S_OUT, "R1", 16'h003D);
    // R1 input direction: peripheral drives
    wr(4'd1, 8'h00);
    chk(S_OUT, "R1", 16'h0081);
    chk(S_OE, "R2", 16'h000F);

    // R6 pull-up gating with driven pins, bit 7 open-drain keeps it
    chk(S_PU, "R6", 16'h00A0);
    // R7 analog select and low-power suppress
    @(negedge clk); analog_sel = 8'h20;
    chk(S_PU, "R7", 16'h0080);
    @(negedge clk); analog_sel = 8'h00; pu_suppress = 1'b1;
    chk(S_PU, "R7", 16'h00A0);
    @(negedge clk); low_power = 1'b1;
    chk(S_PU, "R7", 16'h0000);
    @(negedge clk); low_power = 1'b0; pu_suppress = 1'b0; per_oe = 8'h00;
    chk(S_PU, "R6", 16'h00A5);

    // R3/R5 input gate off
    @(negedge clk); pin_in = 8'h5A;
    repeat (3) @(posedge clk);
    rd(4'd0, 1'b0, "R3", 8'h00);
    rd(4'd3, 1'b0, "R5", 8'h00);
    wr(4'd2, 8'hFF);
    rd(4'd3, 1'b0, "R5", 8'h5A);
    // R5 latency: pin change together with pin-state read
    @(negedge clk); pin_in = 8'hC3; bus_addr = 4'd3;
    chk(S_RD, "R5", 16'h005A);
    chk(S_RD, "R5", 16'h005A);
    chk(S_RD, "R5", 16'h00C3);
    rd(4'd0, 1'b0, "R3", 8'hC3);
    rd(4'd0, 1'b1, "R4", 8'h3C);
    wr(4'd2, 8'h0F);
    rd(4'd0, 1'b0, "R3", 8'h03);
    chk(S_PIN, "R12", 16'h0003);

    // R4 rmw read with peripheral enabled, output direction
    wr(4'd1, 8'hFF);
    @(negedge clk); per_oe = 8'hFF; per_out = 8'hC0;
    rd(4'd0, 1'b1, "R4", 8'h3C);
    rd(4'd0, 1'b0, "R3", 8'h3C);
    // R4 collision: write and rmw read in the same cycle
    @(negedge clk); bus_addr = 4'd0; bus_we = 1'b1; bus_wdata = 8'h77; bus_rmw = 1'b1;
    chk(S_RD, "R4", 16'h003C);
    bus_we = 1'b0;
    rd(4'd0, 1'b1, "R4", 8'h77);

    // R8 drive codes
    wr(4'd5, 8'h0F);
    wr(4'd6, 8'h33);
    chk(S_DRV, "R8", 16'h0A5A);
    rd(4'd6, 1'b0, "R13", 8'h33);
    // R9 level codes
    wr(4'd7, 8'h55);
    wr(4'd8, 8'h33);
    chk(S_LVL, "R9", 16'h1B1B);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule